// File: doc/BRIEF.md
# Warp Pre-Execution Controller

This block steers one warp of a simplified GPU pipeline model around long-latency stalls. In normal mode it steps the warp's program counter, takes the decoded instruction presented at that counter and emits an issue command. When a global load issued in normal mode misses, the warp does not sit idle. It moves into a pre-execution mode and keeps walking the instructions that follow the load. It tracks which architectural registers are poisoned by the outstanding result. Instructions that touch no poisoned register run early, and their destinations are redirected to spare physical registers drawn from a free pool.

Global loads met during pre-execution become L1 prefetch commands that write no register. A store, a branch on a poisoned register, or the lack of a spare register stops the scan, and the warp then waits. When the missing data returns, the warp resumes at the instruction after the load. Any instruction already run early is not recomputed: a reuse command moves its result out of the spare register, and that spare register goes back to the pool.

The front end is modelled as a combinational lookup: the block drives `fetch_pc` and receives the decoded fields of that instruction in the same cycle. Branches are treated as falling through.

Top module: `warp_preexec_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mode` is 0 (normal), `fetch_pc` is 0, and no issue, prefetch, pool pop or release is signalled.
- R2: In normal mode, every cycle with `inst_valid` high issues the instruction with `issue_kind` 0 (normal) and `issue_pc` equal to `fetch_pc`, and the counter advances by one. With `inst_valid` low, nothing issues and the counter holds. The opcode encoding is 0 ALU, 1 global load, 2 store, 3 branch.
- R3: A global load issued normally while `miss_i` is high places the warp in pre-execution (`mode` 1) on the next cycle, with `fetch_pc` at the load's address plus one and the load's destination marked as dependent.
- R4: In pre-execution, an ALU op or load that reads a marked register issues nothing, marks its own destination, and the scan moves on. An ALU op reads source A and source B; a load and a branch read source A only.
- R5: An independent ALU op in pre-execution issues with `issue_kind` 1 and pops the pool, and `issue_preg` carries the popped register. A source written earlier in the same episode is flagged as renamed, and its spare register is given.
- R6: An independent ALU op that writes a marked register clears that mark, so later readers of that register are independent.
- R7: An independent load in pre-execution raises `pf_valid` with `pf_pc` equal to its address, issues nothing, pops nothing, and marks its destination.
- R8: A store, or a branch reading a marked register, moves the warp into waiting (`mode` 2) on the next cycle with `fetch_pc` held. An independent branch is skipped. While waiting, nothing issues, prefetches or pops.
- R9: An independent ALU op that finds the pool empty, or all 8 rename entries in use, moves the warp into waiting without issuing or popping.
- R10: `wake_i` in pre-execution or waiting returns the warp to normal mode on the next cycle at the instruction after the missed load, with all marks cleared. `wake_i` in normal mode has no effect.
- R11: In normal mode, an instruction that was run early issues with `issue_kind` 2 (reuse), and `issue_preg` carries its spare register. In the same cycle, `rel_valid` returns that register on `rel_preg`, and the entry is freed.
- R12: When `wake_i` arrives in the same cycle as an instruction that could be run early, the wake wins: nothing issues or pops in that cycle, and the instruction later issues normally.
- R13: A miss taken while rename entries are still outstanding sends the warp straight to waiting without pre-executing, and the outstanding entries are still reused after the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | output | PC_W | Address of the instruction being examined |
| inst_valid | input | 1 | Decoded instruction at `fetch_pc` is present |
| inst_op | input | 2 | Opcode: 0 ALU, 1 global load, 2 store, 3 branch |
| inst_dst | input | AW | Destination architectural register |
| inst_src_a | input | AW | Source A architectural register |
| inst_src_b | input | AW | Source B architectural register |
| miss_i | input | 1 | The load issuing this cycle misses and waits off-chip |
| wake_i | input | 1 | Data of the missed load has returned |
| pool_avail | input | 1 | Free pool holds a spare physical register |
| pool_preg | input | PREG_W | Spare register at the head of the pool |
| pool_pop | output | 1 | Take the head of the pool |
| issue_valid | output | 1 | Issue command present |
| issue_kind | output | 2 | 0 normal, 1 early, 2 reuse |
| issue_pc | output | PC_W | Address of the issued instruction |
| issue_preg | output | PREG_W | Spare register written (early) or read (reuse) |
| issue_srca_ren | output | 1 | Source A read from a spare register |
| issue_srca_preg | output | PREG_W | Spare register for source A |
| issue_srcb_ren | output | 1 | Source B read from a spare register |
| issue_srcb_preg | output | PREG_W | Spare register for source B |
| pf_valid | output | 1 | L1 prefetch request |
| pf_pc | output | PC_W | Address of the load turned into a prefetch |
| rel_valid | output | 1 | Return a spare register to the pool |
| rel_preg | output | PREG_W | Register returned |
| mode | output | 2 | 0 normal, 1 pre-execution, 2 waiting |

## Verification
The collision that matters is the returning data (`wake_i`) landing in the same cycle as an independent ALU op that pre-execution would otherwise run early. A directed scenario takes a miss and lets the first candidate appear at `fetch_pc`, then raises the wake in exactly that cycle. It checks that neither an issue nor a pool pop appears in that cycle. On the next cycle the same address must issue as a plain normal instruction with no reuse. A second overlap, a fresh miss while rename entries from the first stall are still pending, is driven by marking a prefetched load as missing on resume. In that case the warp must wait without pre-executing, and the old entry must still be reused afterwards.

// File: rtl/pxc_pkg.sv
// Package: shared encodings for the warp pre-execution controller.
// Assumes two-bit opcode, mode and issue-kind fields on the block ports.
package pxc_pkg;
    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_BRANCH = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_PRE    = 2'd1,
        MODE_WAIT   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ISS_NORMAL = 2'd0,
        ISS_PRE    = 2'd1,
        ISS_REUSE  = 2'd2
    } iss_e;
endpackage

// File: rtl/pxc_dep_track.sv
// Module: per-architectural-register poison bits.
// A seed replaces the whole vector with one set bit (the missed load's
// destination). Mark/unmark touch one bit. Clear wipes all bits.
// Assumes seed, clear and mark/unmark are never requested together.
module pxc_dep_track #(
    parameter int NUM_ARCH = 32,
    parameter int AW       = $clog2(NUM_ARCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic          seed_en,
    input  logic          mark_en,
    input  logic          unmark_en,
    input  logic [AW-1:0] wr_reg,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic          dep_a,
    output logic          dep_b
);
    logic [NUM_ARCH-1:0] poison_q;

    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_bit
        // Update one poison bit from the seed, mark and unmark strobes.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                poison_q[i] <= 1'b0;
            end else if (seed_en) begin
                poison_q[i] <= (wr_reg == AW'(i));
            end else if (mark_en && wr_reg == AW'(i)) begin
                poison_q[i] <= 1'b1;
            end else if (unmark_en && wr_reg == AW'(i)) begin
                poison_q[i] <= 1'b0;
            end
        end
    end

    // Read both source bits for the instruction at the fetch address.
    always_comb begin
        dep_a = poison_q[rd_a];
        dep_b = poison_q[rd_b];
    end
endmodule

// File: rtl/pxc_rename_tbl.sv
// Module: spare-register rename table.
// Each entry holds a spare physical register tagged with the address of
// the instruction that produced it. A per-architectural-register map
// points at the newest entry written in the current episode, for source
// renaming. Assumes at most one entry per address, and that the map is
// cleared at every mode change.
module pxc_rename_tbl #(
    parameter int NUM_ENT  = 8,
    parameter int NUM_ARCH = 32,
    parameter int PC_W     = 16,
    parameter int PREG_W   = 8,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int IW       = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [AW-1:0]     alloc_arch,
    input  logic [PREG_W-1:0] alloc_preg,
    input  logic [PC_W-1:0]   look_pc,
    input  logic              release_en,
    input  logic              map_clear,
    input  logic              map_kill,
    input  logic [AW-1:0]     src_a,
    input  logic [AW-1:0]     src_b,
    output logic              hit,
    output logic [PREG_W-1:0] hit_preg,
    output logic              ren_a,
    output logic [PREG_W-1:0] preg_a,
    output logic              ren_b,
    output logic [PREG_W-1:0] preg_b,
    output logic              full,
    output logic              empty
);
    logic [NUM_ENT-1:0] ent_v;
    logic [PC_W-1:0]    ent_pc   [NUM_ENT];
    logic [PREG_W-1:0]  ent_preg [NUM_ENT];
    logic [NUM_ENT-1:0] hit_vec;
    logic [IW-1:0]      free_idx;
    logic [NUM_ARCH-1:0] map_v;
    logic [IW-1:0]      map_idx  [NUM_ARCH];

    // Pick the lowest-numbered free entry for the next allocation.
    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_v[i]) free_idx = IW'(i);
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        // Compare this entry's tag with the fetch address.
        assign hit_vec[e] = ent_v[e] && (ent_pc[e] == look_pc);

        // Fill the entry on allocation and free it on reuse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_v[e]    <= 1'b0;
                ent_pc[e]   <= '0;
                ent_preg[e] <= '0;
            end else if (alloc_en && free_idx == IW'(e)) begin
                ent_v[e]    <= 1'b1;
                ent_pc[e]   <= look_pc;
                ent_preg[e] <= alloc_preg;
            end else if (release_en && hit_vec[e]) begin
                ent_v[e] <= 1'b0;
            end
        end
    end

    // Merge the matching entry's spare register onto one bus.
    always_comb begin
        hit_preg = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_vec[i]) hit_preg = hit_preg | ent_preg[i];
        end
    end

    assign hit   = |hit_vec;
    assign full  = &ent_v;
    assign empty = ~|ent_v;

    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_map
        // Track which entry last wrote this register in the episode.
        always_ff @(posedge clk) begin
            if (!rst_n || map_clear) begin
                map_v[r]   <= 1'b0;
                map_idx[r] <= '0;
            end else if (alloc_en && alloc_arch == AW'(r)) begin
                map_v[r]   <= 1'b1;
                map_idx[r] <= free_idx;
            end else if (map_kill && alloc_arch == AW'(r)) begin
                map_v[r] <= 1'b0;
            end
        end
    end

    // Resolve both sources through the episode map.
    always_comb begin
        ren_a  = map_v[src_a];
        preg_a = ent_preg[map_idx[src_a]];
        ren_b  = map_v[src_b];
        preg_b = ent_preg[map_idx[src_b]];
    end
endmodule

// File: rtl/pxc_seq.sv
// Module: mode sequencer and program counter for one warp.
// Decides per cycle whether the fetched instruction issues normally,
// runs early, is reused, is skipped, becomes a prefetch, or stops the
// scan. All decisions are combinational on the fetched instruction.
// Assumes branches fall through in this model.
module pxc_seq
    import pxc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inst_valid,
    input  logic [1:0]      inst_op,
    input  logic            miss_i,
    input  logic            wake_i,
    input  logic            pool_avail,
    input  logic            dep_a,
    input  logic            dep_b,
    input  logic            hit,
    input  logic            full,
    input  logic            empty,
    output logic [PC_W-1:0] pc,
    output logic [1:0]      mode,
    output logic            issue_valid,
    output logic [1:0]      issue_kind,
    output logic            pool_pop,
    output logic            pf_valid,
    output logic            rel_en,
    output logic            dep_seed,
    output logic            dep_clear,
    output logic            dep_mark,
    output logic            dep_unmark,
    output logic            map_clear,
    output logic            map_kill,
    output logic            alloc_en
);
    mode_e           mode_q, mode_n;
    logic [PC_W-1:0] pc_q, pc_n, resume_q, resume_n;
    iss_e            kind;
    op_e             op;
    logic            uses_b, poisoned;

    assign op       = op_e'(inst_op);
    assign uses_b   = (op == OP_ALU) || (op == OP_STORE);
    assign poisoned = dep_a || (uses_b && dep_b);

    // Compute next mode, next address and all per-cycle strobes.
    always_comb begin
        mode_n      = mode_q;
        pc_n        = pc_q;
        resume_n    = resume_q;
        kind        = ISS_NORMAL;
        issue_valid = 1'b0;
        pool_pop    = 1'b0;
        pf_valid    = 1'b0;
        rel_en      = 1'b0;
        dep_seed    = 1'b0;
        dep_clear   = 1'b0;
        dep_mark    = 1'b0;
        dep_unmark  = 1'b0;
        map_clear   = 1'b0;
        map_kill    = 1'b0;
        alloc_en    = 1'b0;
        case (mode_q)
            MODE_NORMAL: begin
                if (inst_valid) begin
                    issue_valid = 1'b1;
                    pc_n        = pc_q + PC_W'(1);
                    if (hit) begin
                        kind   = ISS_REUSE;
                        rel_en = 1'b1;
                    end else if (op == OP_LOAD && miss_i) begin
                        dep_seed  = 1'b1;
                        map_clear = 1'b1;
                        resume_n  = pc_q + PC_W'(1);
                        mode_n    = empty ? MODE_PRE : MODE_WAIT;
                    end
                end
            end
            MODE_PRE: begin
                if (wake_i) begin
                    mode_n    = MODE_NORMAL;
                    pc_n      = resume_q;
                    dep_clear = 1'b1;
                    map_clear = 1'b1;
                end else if (inst_valid) begin
                    case (op)
                        OP_STORE: mode_n = MODE_WAIT;
                        OP_BRANCH: begin
                            if (poisoned) mode_n = MODE_WAIT;
                            else          pc_n   = pc_q + PC_W'(1);
                        end
                        OP_LOAD: begin
                            dep_mark = 1'b1;
                            map_kill = 1'b1;
                            pf_valid = !poisoned;
                            pc_n     = pc_q + PC_W'(1);
                        end
                        default: begin
                            if (poisoned) begin
                                dep_mark = 1'b1;
                                map_kill = 1'b1;
                                pc_n     = pc_q + PC_W'(1);
                            end else if (full || !pool_avail) begin
                                mode_n = MODE_WAIT;
                            end else begin
                                issue_valid = 1'b1;
                                kind        = ISS_PRE;
                                pool_pop    = 1'b1;
                                alloc_en    = 1'b1;
                                dep_unmark  = 1'b1;
                                pc_n        = pc_q + PC_W'(1);
                            end
                        end
                    endcase
                end
            end
            MODE_WAIT: begin
                if (wake_i) begin
                    mode_n    = MODE_NORMAL;
                    pc_n      = resume_q;
                    dep_clear = 1'b1;
                    map_clear = 1'b1;
                end
            end
            default: mode_n = MODE_NORMAL;
        endcase
    end

    // Register mode, fetch address and resume address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_NORMAL;
            pc_q     <= '0;
            resume_q <= '0;
        end else begin
            mode_q   <= mode_n;
            pc_q     <= pc_n;
            resume_q <= resume_n;
        end
    end

    assign pc         = pc_q;
    assign mode       = mode_q;
    assign issue_kind = kind;
endmodule

// File: rtl/warp_preexec_ctrl.sv
// Module: top of the warp pre-execution controller.
// Wires the sequencer, the poison tracker and the rename table, and forms
// the issue, prefetch and release commands. Assumes a combinational
// front end that returns the decoded instruction at fetch_pc.
module warp_preexec_ctrl #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_ENT  = 8,
    parameter int PC_W     = 16,
    parameter int PREG_W   = 8,
    parameter int AW       = $clog2(NUM_ARCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   fetch_pc,
    input  logic              inst_valid,
    input  logic [1:0]        inst_op,
    input  logic [AW-1:0]     inst_dst,
    input  logic [AW-1:0]     inst_src_a,
    input  logic [AW-1:0]     inst_src_b,
    input  logic              miss_i,
    input  logic              wake_i,
    input  logic              pool_avail,
    input  logic [PREG_W-1:0] pool_preg,
    output logic              pool_pop,
    output logic              issue_valid,
    output logic [1:0]        issue_kind,
    output logic [PC_W-1:0]   issue_pc,
    output logic [PREG_W-1:0] issue_preg,
    output logic              issue_srca_ren,
    output logic [PREG_W-1:0] issue_srca_preg,
    output logic              issue_srcb_ren,
    output logic [PREG_W-1:0] issue_srcb_preg,
    output logic              pf_valid,
    output logic [PC_W-1:0]   pf_pc,
    output logic              rel_valid,
    output logic [PREG_W-1:0] rel_preg,
    output logic [1:0]        mode
);
    import pxc_pkg::*;

    logic dep_a, dep_b, hit, full, empty;
    logic rel_en, dep_seed, dep_clear, dep_mark, dep_unmark;
    logic map_clear, map_kill, alloc_en;
    logic ren_a, ren_b, early;
    logic [PREG_W-1:0] hit_preg, preg_a, preg_b;

    pxc_seq #(.PC_W(PC_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_op(inst_op),
        .miss_i(miss_i), .wake_i(wake_i), .pool_avail(pool_avail),
        .dep_a(dep_a), .dep_b(dep_b), .hit(hit), .full(full), .empty(empty),
        .pc(fetch_pc), .mode(mode), .issue_valid(issue_valid),
        .issue_kind(issue_kind), .pool_pop(pool_pop), .pf_valid(pf_valid),
        .rel_en(rel_en), .dep_seed(dep_seed), .dep_clear(dep_clear),
        .dep_mark(dep_mark), .dep_unmark(dep_unmark), .map_clear(map_clear),
        .map_kill(map_kill), .alloc_en(alloc_en)
    );

    pxc_dep_track #(.NUM_ARCH(NUM_ARCH), .AW(AW)) dep_i (
        .clk(clk), .rst_n(rst_n), .clear_all(dep_clear), .seed_en(dep_seed),
        .mark_en(dep_mark), .unmark_en(dep_unmark), .wr_reg(inst_dst),
        .rd_a(inst_src_a), .rd_b(inst_src_b), .dep_a(dep_a), .dep_b(dep_b)
    );

    pxc_rename_tbl #(
        .NUM_ENT(NUM_ENT), .NUM_ARCH(NUM_ARCH), .PC_W(PC_W),
        .PREG_W(PREG_W), .AW(AW)
    ) tbl_i (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_arch(inst_dst),
        .alloc_preg(pool_preg), .look_pc(fetch_pc), .release_en(rel_en),
        .map_clear(map_clear), .map_kill(map_kill), .src_a(inst_src_a),
        .src_b(inst_src_b), .hit(hit), .hit_preg(hit_preg), .ren_a(ren_a),
        .preg_a(preg_a), .ren_b(ren_b), .preg_b(preg_b), .full(full),
        .empty(empty)
    );

    assign early = issue_valid && (issue_kind == ISS_PRE);

    // Form the issue register fields for early and reuse commands.
    always_comb begin
        issue_pc        = fetch_pc;
        issue_preg      = '0;
        if (issue_valid && issue_kind == ISS_REUSE) issue_preg = hit_preg;
        else if (early)                            issue_preg = pool_preg;
        issue_srca_ren  = early && ren_a;
        issue_srca_preg = (early && ren_a) ? preg_a : '0;
        issue_srcb_ren  = early && ren_b;
        issue_srcb_preg = (early && ren_b) ? preg_b : '0;
    end

    assign pf_pc     = fetch_pc;
    assign rel_valid = rel_en;
    assign rel_preg  = hit_preg;
endmodule

// File: rtl/pxc_checker.sv
// Module: assertion checker bound to warp_preexec_ctrl.
// Observes ports only; assumes the default encodings of pxc_pkg.
module pxc_checker #(
    parameter int PC_W   = 16,
    parameter int PREG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              wake_i,
    input logic              miss_i,
    input logic [1:0]        inst_op,
    input logic              issue_valid,
    input logic [1:0]        issue_kind,
    input logic [PREG_W-1:0] issue_preg,
    input logic              pool_pop,
    input logic              pf_valid,
    input logic              rel_valid,
    input logic [PREG_W-1:0] rel_preg
);
    AST_POP_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        pool_pop |-> (mode == 2'd1 && issue_valid && issue_kind == 2'd1)); // R5
    AST_PF_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (!issue_valid && !pool_pop && mode == 2'd1)); // R7
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!issue_valid && !pf_valid && !pool_pop)); // R8
    AST_WAIT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !wake_i) |=> $stable(fetch_pc)); // R8
    AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && mode != 2'd0) |=> (mode == 2'd0)); // R10
    AST_REL_WITH_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (issue_valid && issue_kind == 2'd2 && rel_preg == issue_preg)); // R11
    AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && mode == 2'd1) |-> (!issue_valid && !pool_pop)); // R12
    AST_MISS_LEAVES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && issue_valid && issue_kind == 2'd0 && inst_op == 2'd1 && miss_i)
        |=> (mode != 2'd0)); // R3
endmodule

bind warp_preexec_ctrl pxc_checker #(.PC_W(PC_W), .PREG_W(PREG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fetch_pc(fetch_pc),
    .wake_i(wake_i), .miss_i(miss_i), .inst_op(inst_op),
    .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_preg(issue_preg), .pool_pop(pool_pop), .pf_valid(pf_valid),
    .rel_valid(rel_valid), .rel_preg(rel_preg)
);

// File: tb/warp_preexec_ctrl_tb_top.sv
module warp_preexec_ctrl_tb_top;
    localparam int PC_W = 16;
    localparam int PREG_W = 8;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [PC_W-1:0] fetch_pc;
    logic iv = 1'b0, wake = 1'b0, pool_av = 1'b1;
    logic miss_w, pool_pop, issue_valid, srca_ren, srcb_ren, pf_valid, rel_valid;
    logic [1:0] op_w, issue_kind, mode;
    logic [AW-1:0] dst_w, sa_w, sb_w;
    logic [PC_W-1:0] issue_pc, pf_pc;
    logic [PREG_W-1:0] issue_preg, srca_preg, srcb_preg, rel_preg;
    logic [PREG_W-1:0] next_preg;

    logic [1:0]    p_op   [0:63];
    logic [AW-1:0] p_dst  [0:63];
    logic [AW-1:0] p_sa   [0:63];
    logic [AW-1:0] p_sb   [0:63];
    logic          p_miss [0:63];

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    assign op_w   = p_op[fetch_pc[5:0]];
    assign dst_w  = p_dst[fetch_pc[5:0]];
    assign sa_w   = p_sa[fetch_pc[5:0]];
    assign sb_w   = p_sb[fetch_pc[5:0]];
    assign miss_w = p_miss[fetch_pc[5:0]] && (op_w == 2'd1);

    always @(posedge clk) begin
        if (!rst_n) next_preg <= 8'd40;
        else if (pool_pop) next_preg <= next_preg + 8'd1;
    end

    warp_preexec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .inst_valid(iv),
        .inst_op(op_w), .inst_dst(dst_w), .inst_src_a(sa_w), .inst_src_b(sb_w),
        .miss_i(miss_w), .wake_i(wake), .pool_avail(pool_av),
        .pool_preg(next_preg), .pool_pop(pool_pop), .issue_valid(issue_valid),
        .issue_kind(issue_kind), .issue_pc(issue_pc), .issue_preg(issue_preg),
        .issue_srca_ren(srca_ren), .issue_srca_preg(srca_preg),
        .issue_srcb_ren(srcb_ren), .issue_srcb_preg(srcb_preg),
        .pf_valid(pf_valid), .pf_pc(pf_pc), .rel_valid(rel_valid),
        .rel_preg(rel_preg), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_ins(input int pc, input int op, input int d, input int a,
                           input int b, input bit m);
        p_op[pc] = 2'(op); p_dst[pc] = AW'(d); p_sa[pc] = AW'(a);
        p_sb[pc] = AW'(b); p_miss[pc] = m;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; iv = 1'b0; wake = 1'b0; pool_av = 1'b1;
        for (int i = 0; i < 64; i++) set_ins(i, 2, 31, 30, 30, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wake_pulse();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        #1;
    endtask

    // R1, R2, R10: reset state, normal stepping, hold, ignored wake.
    task automatic t_normal();
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 pc", fetch_pc, 0);
        chk("R1 issue", issue_valid, 0);
        chk("R1 pop/pf/rel", {pool_pop, pf_valid, rel_valid}, 0);
        for (int i = 0; i < 4; i++) set_ins(i, 0, 3, 4, 5, 1'b0);
        iv = 1'b1; #1;
        chk("R2 issue", issue_valid, 1);
        chk("R2 kind", issue_kind, 0);
        tick();
        chk("R2 pc advance", fetch_pc, 1);
        chk("R2 issue_pc", issue_pc, 1);
        iv = 1'b0; #1;
        chk("R2 no issue", issue_valid, 0);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk("R2 hold pc", fetch_pc, 1);
        chk("R10 wake ignored in normal", mode, 0);
    endtask

    // R3-R8, R10, R11: full episode with reuse afterwards.
    task automatic t_episode();
        do_reset();
        set_ins(0, 1, 1, 2, 2, 1'b1);
        set_ins(1, 0, 3, 1, 4, 1'b0);
        set_ins(2, 0, 5, 6, 7, 1'b0);
        set_ins(3, 0, 8, 5, 6, 1'b0);
        set_ins(4, 1, 9, 6, 6, 1'b0);
        set_ins(5, 0, 10, 9, 6, 1'b0);
        set_ins(6, 0, 3, 6, 7, 1'b0);
        set_ins(7, 0, 11, 3, 6, 1'b0);
        set_ins(8, 3, 0, 6, 6, 1'b0);
        set_ins(9, 2, 0, 6, 7, 1'b0);
        iv = 1'b1; #1;
        chk("R3 load issues normally", issue_kind, 0);
        tick();
        chk("R3 mode pre", mode, 1);
        chk("R3 pc after load", fetch_pc, 1);
        chk("R4 dependent skipped", issue_valid, 0);
        tick();
        chk("R5 early issue", {issue_valid, issue_kind}, 3'b101);
        chk("R5 preg", issue_preg, 40);
        chk("R5 pop", pool_pop, 1);
        tick();
        chk("R5 preg second", issue_preg, 41);
        chk("R5 srca renamed", {srca_ren, srcb_ren}, 2'b10);
        chk("R5 srca preg", srca_preg, 40);
        tick();
        chk("R7 prefetch", pf_valid, 1);
        chk("R7 pf_pc", pf_pc, 4);
        chk("R7 no issue/pop", {issue_valid, pool_pop}, 0);
        tick();
        chk("R7 prefetched dst marked", issue_valid, 0);
        tick();
        chk("R6 waw write early", issue_kind, 1);
        chk("R6 preg", issue_preg, 42);
        tick();
        chk("R6 mark cleared", issue_valid, 1);
        chk("R6 srca preg", srca_preg, 42);
        tick();
        chk("R8 indep branch skipped", {mode, issue_valid}, 3'b010);
        tick();
        chk("R8 store not issued", issue_valid, 0);
        tick();
        chk("R8 wait", mode, 2);
        chk("R8 pc held", fetch_pc, 9);
        tick();
        chk("R8 still wait", {mode, issue_valid, pf_valid}, 4'b1000);
        wake_pulse();
        chk("R10 normal", mode, 0);
        chk("R10 resume pc", fetch_pc, 1);
        chk("R10 kind", issue_kind, 0);
        tick();
        chk("R11 reuse kind", issue_kind, 2);
        chk("R11 reuse preg", issue_preg, 40);
        chk("R11 release", {rel_valid, rel_preg}, {1'b1, 8'd40});
        tick();
        chk("R11 reuse second", issue_preg, 41);
        tick();
        chk("R10 load normal", {issue_kind, rel_valid}, 0);
        tick();
        chk("R10 marks cleared", issue_kind, 0);
        tick();
        chk("R11 reuse 42", {issue_kind, issue_preg}, {2'd2, 8'd42});
        tick();
        chk("R11 reuse 43", {issue_kind, issue_preg}, {2'd2, 8'd43});
        tick();
        chk("R11 freed", {issue_kind, rel_valid}, 0);
    endtask

    // R9: table full, then empty pool.
    task automatic t_full();
        do_reset();
        set_ins(0, 1, 1, 2, 2, 1'b1);
        for (int i = 1; i < 10; i++) set_ins(i, 0, 9 + i, 20, 21, 1'b0);
        iv = 1'b1;
        tick();
        for (int i = 1; i < 9; i++) begin
            chk("R9 early until full", issue_kind, 1);
            tick();
        end
        chk("R9 full no issue", {issue_valid, pool_pop}, 0);
        tick();
        chk("R9 full wait", mode, 2);
        wake_pulse();
        chk("R11 reuse after full", {issue_kind, rel_preg}, {2'd2, 8'd40});
        do_reset();
        pool_av = 1'b0;
        set_ins(0, 1, 1, 2, 2, 1'b1);
        set_ins(1, 0, 5, 6, 7, 1'b0);
        iv = 1'b1;
        tick();
        chk("R9 empty pool no issue", {issue_valid, pool_pop}, 0);
        tick();
        chk("R9 empty pool wait", mode, 2);
    endtask

    // R8: branch on a marked register stops the scan.
    task automatic t_branch();
        do_reset();
        set_ins(0, 1, 1, 2, 2, 1'b1);
        set_ins(1, 3, 0, 1, 1, 1'b0);
        iv = 1'b1;
        tick();
        chk("R8 dep branch silent", issue_valid, 0);
        tick();
        chk("R8 dep branch wait", mode, 2);
        chk("R8 dep branch pc", fetch_pc, 1);
    endtask

    // R13: second miss with an entry outstanding.
    task automatic t_second_miss();
        do_reset();
        set_ins(0, 1, 1, 2, 2, 1'b1);
        set_ins(1, 1, 2, 5, 5, 1'b1);
        set_ins(2, 0, 6, 7, 8, 1'b0);
        iv = 1'b1;
        tick();
        chk("R13 first pf", pf_valid, 1);
        tick();
        chk("R13 entry made", issue_preg, 40);
        tick();
        tick();
        chk("R13 waiting", mode, 2);
        wake_pulse();
        chk("R13 load reissue", {issue_valid, issue_kind}, 3'b100);
        tick();
        chk("R13 straight to wait", mode, 2);
        chk("R13 no pop", pool_pop, 0);
        wake_pulse();
        chk("R13 entry reused", {issue_kind, issue_preg}, {2'd2, 8'd40});
    endtask

    // R12: wake in the same cycle as an early-run candidate.
    task automatic t_wake_collide();
        do_reset();
        set_ins(0, 1, 1, 2, 2, 1'b1);
        set_ins(1, 0, 5, 6, 7, 1'b0);
        iv = 1'b1;
        tick();
        chk("R12 in pre", mode, 1);
        wake = 1'b1; #1;
        chk("R12 no issue/pop", {issue_valid, pool_pop}, 0);
        @(negedge clk);
        wake = 1'b0; #1;
        chk("R12 normal", mode, 0);
        chk("R12 issued normally", {issue_valid, issue_kind, rel_valid}, 4'b1000);
    endtask

    initial begin
        t_normal();
        t_episode();
        t_full();
        t_branch();
        t_second_miss();
        t_wake_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule